// File: doc/BRIEF.md
# Bus Tenure Data-Phase Limiter

This block sits beside a DMA bus master and caps how many FIFO data phases the master may run while it holds the bus. Software programs an 8-bit limit. At the start of each new bus tenure, the limit is copied into a separate run-time down-counter. Each counted data phase lowers that counter by one. When a phase brings the counter to zero, the block raises `burst_end` in that same cycle and withdraws `may_continue`, which tells the master to give up the bus.

If the master is preempted, the counter holds its value. When the bus is granted again, counting carries on from that value without a reload. Phases that move descriptors or the initialization block are flagged as exempt and are never counted.

In unlimited mode the counter is left alone. The master then bursts for as long as the FIFO on the active side permits: for transmit, while the transmit FIFO is not full; for receive, while the receive FIFO is not empty.

The control is a four-state machine:

| State | Meaning |
|---|---|
| `ST_IDLE` | No tenure since reset. |
| `ST_ACTIVE` | Tenure running. |
| `ST_FROZEN` | Preempted; the count is held. |
| `ST_DONE` | Limit reached or FIFO stop; waiting for a new tenure. |

Its transitions are:

| Transition | Trigger |
|---|---|
| IDLE→ACTIVE and DONE→ACTIVE | `grant_new`, which loads the counter. |
| ACTIVE→DONE | The final counted phase, or the FIFO stop condition in unlimited mode. |
| ACTIVE→FROZEN | `preempt`. |
| FROZEN→ACTIVE | `grant_new` or `grant_resume`, with no reload. |

Top module: `tenure_limiter`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0, `may_continue` and `burst_end` are 0, and the programmed limit is 16 (0x10).
- R2: `grant_new` in `ST_IDLE` or `ST_DONE` loads the run-time counter from the limit and enters `ST_ACTIVE`. After that clock edge, `may_continue` is 1.
- R3: In `ST_ACTIVE` with unlimited mode off, each counted phase lowers the run-time counter by one. A counted phase is `phase_done`=1 with `phase_exempt`=0. `cfg_rd_data` always returns the run-time counter, never the programmed limit.
- R4: A programmed limit of 0 loads the counter with 1, so exactly one phase is allowed.
- R5: `burst_end` is 1 in the same cycle as the counted phase that takes the counter from 1 to 0. After that edge the state is `ST_DONE`, `may_continue` is 0 and the counter reads 0.
- R6: A phase with `phase_exempt`=1 leaves the counter unchanged and never raises `burst_end`.
- R7: `preempt` in `ST_ACTIVE` enters `ST_FROZEN` with the counter held. A counted phase in the same cycle is applied first. In `ST_FROZEN`, `may_continue` is 0 and phases are not counted. A later `grant_new` or `grant_resume` returns to `ST_ACTIVE` without a reload.
- R8: `grant_resume` in `ST_IDLE` or `ST_DONE` has no effect.
- R9: In unlimited mode (`unlimited`=1), phases do not change the counter. The stop condition is `rx_fifo_empty` when `dir_rx`=1 and `tx_fifo_full` when `dir_rx`=0. `may_continue` is 1 in `ST_ACTIVE` while the stop condition is false. When the stop condition is true in `ST_ACTIVE`, `burst_end` is 1 in that cycle and the next state is `ST_DONE`.
- R10: `cfg_wr_en` writes `cfg_wr_data` into the limit only while `stop` or `suspend` is 1; otherwise the write is ignored. Holding `stop` does not change the limit.
- R11: `grant_new` while in `ST_ACTIVE` does not reload the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop | input | 1 | Controller stopped; permits limit writes |
| suspend | input | 1 | Controller suspended; permits limit writes |
| cfg_wr_en | input | 1 | Limit write strobe |
| cfg_wr_data | input | 8 | Limit write value |
| cfg_rd_data | output | 8 | Run-time counter readback |
| unlimited | input | 1 | Ignore the limit and burst on the FIFO condition |
| grant_new | input | 1 | Start of a new bus tenure |
| grant_resume | input | 1 | Bus regranted after preemption |
| preempt | input | 1 | Master preempted |
| phase_done | input | 1 | One FIFO data phase completes |
| phase_exempt | input | 1 | Current phase is a descriptor or initialization transfer |
| dir_rx | input | 1 | 1 for receive, 0 for transmit |
| tx_fifo_full | input | 1 | Transmit FIFO full |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| may_continue | output | 1 | Master may run another data phase |
| burst_end | output | 1 | Release the bus after this cycle |

## Verification
`burst_end` is combinational: it is due in the same cycle as the final counted phase or the FIFO stop condition. The bench therefore reads it after the inputs settle and before the next rising edge. `cfg_rd_data` and `may_continue` come from registers and change one edge after the grant, phase, preempt or write that moves them. The bench samples them 1 ns after that edge, and all stimulus changes at that same offset, away from the edge. An ignored write is judged by starting a fresh tenure and reading the loaded count.

// File: rtl/tl_pkg.sv
package tl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_FROZEN = 2'd2,
        ST_DONE   = 2'd3
    } tl_state_t;
endpackage

// File: rtl/tl_limit_reg.sv
module tl_limit_reg #(
    parameter int W         = 8,
    parameter int RESET_VAL = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_allow,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] load_val
);
    localparam logic [W-1:0] RST = W'(RESET_VAL);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] limit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                limit_q <= RST;
        else if (wr_en && wr_allow) limit_q <= wr_data;
    end

    // a zero limit still grants a single phase
    always_comb load_val = (limit_q == '0) ? ONE : limit_q;
endmodule

// File: rtl/tl_runcount.sv
module tl_runcount #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count <= '0;
        else if (load)             count <= load_val;
        else if (dec && count != 0) count <= count - 1'b1;
    end
endmodule

// File: rtl/tenure_limiter.sv
module tenure_limiter
    import tl_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int RESET_LIMIT = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop,
    input  logic             suspend,
    input  logic             cfg_wr_en,
    input  logic [CNT_W-1:0] cfg_wr_data,
    output logic [CNT_W-1:0] cfg_rd_data,
    input  logic             unlimited,
    input  logic             grant_new,
    input  logic             grant_resume,
    input  logic             preempt,
    input  logic             phase_done,
    input  logic             phase_exempt,
    input  logic             dir_rx,
    input  logic             tx_fifo_full,
    input  logic             rx_fifo_empty,
    output logic             may_continue,
    output logic             burst_end
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    tl_state_t        state_q, state_d;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic             do_load, do_dec, counted, fifo_stop;

    tl_limit_reg #(.W(CNT_W), .RESET_VAL(RESET_LIMIT)) u_limit (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_allow (stop | suspend),
        .wr_data  (cfg_wr_data),
        .load_val (load_val)
    );

    tl_runcount #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .load_val (load_val),
        .dec      (do_dec),
        .count    (count)
    );

    assign counted   = phase_done && !phase_exempt && !unlimited;
    assign fifo_stop = dir_rx ? rx_fifo_empty : tx_fifo_full;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d      = state_q;
        do_load      = 1'b0;
        do_dec       = 1'b0;
        may_continue = 1'b0;
        burst_end    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (grant_new) begin
                    do_load = 1'b1;
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (unlimited) begin
                    may_continue = !fifo_stop;
                    if (fifo_stop) begin
                        burst_end = 1'b1;
                        state_d   = ST_DONE;
                    end else if (preempt) begin
                        state_d = ST_FROZEN;
                    end
                end else begin
                    may_continue = 1'b1;
                    do_dec       = counted;
                    if (counted && count == LAST) begin
                        burst_end = 1'b1;
                        state_d   = ST_DONE;
                    end else if (preempt) begin
                        state_d = ST_FROZEN;
                    end
                end
            end
            ST_FROZEN: begin
                if (grant_new || grant_resume) state_d = ST_ACTIVE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign cfg_rd_data = count;
endmodule

// File: rtl/tenure_limiter_chk.sv
module tenure_limiter_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             unlimited,
    input logic             preempt,
    input logic             phase_done,
    input logic             phase_exempt,
    input logic             may_continue,
    input logic             burst_end,
    input logic [CNT_W-1:0] cfg_rd_data
);
    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (may_continue && phase_done && !phase_exempt && !unlimited && !burst_end)
        |=> cfg_rd_data == $past(cfg_rd_data) - 1'b1);

    assert_nonzero_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (may_continue && !unlimited) |-> cfg_rd_data != '0);

    assert_release_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        burst_end |=> !may_continue);

    assert_end_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_end && !unlimited) |=> cfg_rd_data == '0);

    assert_exempt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (may_continue && !(phase_done && !phase_exempt && !unlimited))
        |=> $stable(cfg_rd_data));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (preempt && may_continue && !burst_end) |=> !may_continue);
endmodule

bind tenure_limiter tenure_limiter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .unlimited    (unlimited),
    .preempt      (preempt),
    .phase_done   (phase_done),
    .phase_exempt (phase_exempt),
    .may_continue (may_continue),
    .burst_end    (burst_end),
    .cfg_rd_data  (cfg_rd_data)
);

// File: tb/tenure_limiter_test.sv
`timescale 1ns/1ps
module tenure_limiter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop = 0, suspend = 0, cfg_wr_en = 0;
    logic [7:0] cfg_wr_data = 0;
    logic [7:0] cfg_rd_data;
    logic       unlimited = 0, grant_new = 0, grant_resume = 0, preempt = 0;
    logic       phase_done = 0, phase_exempt = 0, dir_rx = 0;
    logic       tx_fifo_full = 0, rx_fifo_empty = 0;
    logic       may_continue, burst_end;
    int checks = 0, failures = 0;

    always #2 clk = ~clk;

    tenure_limiter uut (
        .clk(clk), .rst_n(rst_n), .stop(stop), .suspend(suspend),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .unlimited(unlimited), .grant_new(grant_new), .grant_resume(grant_resume),
        .preempt(preempt), .phase_done(phase_done), .phase_exempt(phase_exempt),
        .dir_rx(dir_rx), .tx_fifo_full(tx_fifo_full), .rx_fifo_empty(rx_fifo_empty),
        .may_continue(may_continue), .burst_end(burst_end)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_grant(input bit resume);
        if (resume) grant_resume = 1; else grant_new = 1;
        tick();
        grant_new = 0; grant_resume = 0;
    endtask

    task automatic do_write(input logic [7:0] v);
        cfg_wr_data = v; cfg_wr_en = 1;
        tick();
        cfg_wr_en = 0;
    endtask

    // one phase; returns burst_end seen in that cycle
    task automatic do_phase(input bit exempt, output bit be);
        phase_done = 1; phase_exempt = exempt;
        #1 be = burst_end;
        tick();
        phase_done = 0; phase_exempt = 0;
    endtask

    task automatic drain(input int n);
        bit be;
        for (int i = 0; i < n; i++) do_phase(0, be);
    endtask

    task automatic t_reset();
        chk("R1 readback", cfg_rd_data, 0);
        chk("R1 may_continue", may_continue, 0);
        chk("R1 burst_end", burst_end, 0);
    endtask

    task automatic t_default_limit();
        bit be;
        do_grant(0);
        chk("R1 default limit", cfg_rd_data, 16);
        chk("R2 active", may_continue, 1);
        for (int i = 1; i <= 16; i++) begin
            do_phase(0, be);
            chk("R5 burst_end timing", be, (i == 16));
            chk("R3 count", cfg_rd_data, 16 - i);
        end
        chk("R5 released", may_continue, 0);
    endtask

    task automatic t_write_gate();
        bit be;
        do_write(8'd5);
        do_grant(0);
        chk("R10 ungated write ignored", cfg_rd_data, 16);
        drain(2);
        do_grant(0);
        chk("R11 no reload while active", cfg_rd_data, 14);
        drain(14);
        stop = 1;
        do_write(8'd3);
        tick();
        do_grant(0);
        chk("R10 write under stop", cfg_rd_data, 3);
        do_phase(1, be);
        chk("R6 exempt no burst_end", be, 0);
        chk("R6 exempt count", cfg_rd_data, 3);
        drain(3);
        chk("R3 done", may_continue, 0);
        stop = 0;
    endtask

    task automatic t_zero_limit();
        bit be;
        suspend = 1;
        do_write(8'd0);
        suspend = 0;
        do_grant(0);
        chk("R4 zero loads one", cfg_rd_data, 1);
        do_phase(0, be);
        chk("R4 single phase ends", be, 1);
        chk("R4 released", may_continue, 0);
    endtask

    task automatic t_preempt();
        bit be;
        suspend = 1;
        do_write(8'd5);
        suspend = 0;
        do_grant(0);
        drain(2);
        preempt = 1; phase_done = 1;
        tick();
        preempt = 0; phase_done = 0;
        chk("R7 frozen count", cfg_rd_data, 2);
        chk("R7 frozen hold", may_continue, 0);
        do_phase(0, be);
        chk("R7 no count when frozen", cfg_rd_data, 2);
        do_grant(0);
        chk("R7 new grant keeps count", cfg_rd_data, 2);
        chk("R7 active again", may_continue, 1);
        preempt = 1;
        tick();
        preempt = 0;
        do_grant(1);
        chk("R7 resume keeps count", cfg_rd_data, 2);
        drain(1);
        do_phase(0, be);
        chk("R7 finish after resume", be, 1);
        do_grant(1);
        chk("R8 resume ignored in done", may_continue, 0);
        chk("R8 count untouched", cfg_rd_data, 0);
    endtask

    task automatic t_unlimited();
        unlimited = 1; dir_rx = 0;
        do_grant(0);
        chk("R9 tx continue", may_continue, 1);
        drain(7);
        chk("R9 count frozen", cfg_rd_data, 5);
        chk("R9 still going", may_continue, 1);
        tx_fifo_full = 1;
        #1 chk("R9 tx stop burst_end", burst_end, 1);
        tick();
        chk("R9 tx stopped", may_continue, 0);
        dir_rx = 1;
        do_grant(0);
        chk("R9 rx ignores tx full", may_continue, 1);
        rx_fifo_empty = 1;
        #1 chk("R9 rx stop burst_end", burst_end, 1);
        tick();
        chk("R9 rx stopped", may_continue, 0);
        rx_fifo_empty = 0; tx_fifo_full = 0; unlimited = 0;
    endtask

    initial begin
        #(4 * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #5 rst_n = 1;
        tick();
        t_reset();
        t_default_limit();
        t_write_gate();
        t_zero_limit();
        t_preempt();
        t_unlimited();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule